// File: doc/BRIEF.md
# ECC Hard Error Cache

This block sits on the read return path between a processor's load unit and two ECC-protected tightly coupled memory ports. One port holds code and the other holds data. The error decoder in front of it is outside the block; it presents each returned word already corrected, along with a single-bit-error flag and a double-bit-error flag.

When a word returns with a correctable single-bit error and no cache entry matches it, the block does four things. It records the port, the word address and the corrected word in a small cache. It sends the corrected word back to the failing location as a write-back. It then tells the requester to repeat the access. Any later read that matches a stored entry is answered from the cache, and the memory's data and flags are ignored.

A memory cell with a permanent fault would otherwise fail, be corrected and be retried forever. With the cache in place it is read at most once more. A saturating counter records the single-bit events. A sticky flag rises once the count reaches a threshold that software programs.

Top module: `hard_err_cache`

## Requirements
- R1: A read with `rd_sbe`=1, `rd_dbe`=0 and no cache hit stores {port, address, `rd_data`} in a cache entry; a later read of that port and address returns that word.
- R2: The cycle after such a read, `wb_valid`=1 with `wb_port`, `wb_addr` and `wb_data` equal to the failing read's port, address and corrected data. `rsp_valid`=0 in that cycle. When `wb_valid`=0, the three write-back fields are 0.
- R3: `retry`=1 exactly one cycle after each `wb_valid` pulse, and at no other time.
- R4: A read that hits a valid entry gives `rsp_valid`=1, `rsp_err`=0 and `rsp_data` equal to the stored word on the next cycle. The memory data, `rd_sbe` and `rd_dbe` have no effect: there is no write-back, no count and no flag change.
- R5: Matching compares both the port bit (0 = code port, 1 = data port) and the address. The same address on the other port misses.
- R6: A missing read with `rd_dbe`=1 gives `rsp_valid`=1, `rsp_err`=1 and `rsp_data`=`rd_data` on the next cycle. The double-bit flag takes precedence over `rd_sbe`. It is never cached, never written back and never counted.
- R7: A missing read with both flags low gives `rsp_valid`=1, `rsp_err`=0 and `rsp_data`=`rd_data` on the next cycle. With no read, `rsp_valid`=0 and `rsp_data`=0.
- R8: A new entry goes into the lowest-numbered invalid slot. When every slot is valid, it replaces the slot at a round-robin pointer, starting at 0, which then advances and wraps.
- R9: Each cached single-bit event increments a counter that saturates at its maximum. `sbe_flag` sets in the write-back cycle of the event whose new count is greater than or equal to a nonzero `thresh`. When `thresh`=0, the flag never sets.
- R10: `sbe_flag` stays set until `flag_clr` is high at a clock edge. A set event at the same edge wins over the clear.
- R11: `clr` at a clock edge invalidates every entry and zeroes the counter and the pointer. It leaves `sbe_flag` unchanged and suppresses any capture or count at that edge.
- R12: While `rst_n` is low, all outputs are 0 and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous invalidate of the cache, counter and pointer |
| flag_clr | input | 1 | Clears the sticky threshold flag |
| thresh | input | CW | Threshold for the single-bit event count; 0 disables the flag |
| rd_valid | input | 1 | Memory read return is valid |
| rd_port | input | 1 | 0 = code port, 1 = data port |
| rd_addr | input | AW | Word address of the read |
| rd_data | input | DW | Corrected read data from the decoder |
| rd_sbe | input | 1 | Correctable single-bit error reported |
| rd_dbe | input | 1 | Uncorrectable double-bit error reported |
| rsp_valid | output | 1 | Response to the requester is valid |
| rsp_data | output | DW | Response data |
| rsp_err | output | 1 | Response is an uncorrectable error |
| retry | output | 1 | Requester must reissue the access |
| wb_valid | output | 1 | Corrected write-back request |
| wb_port | output | 1 | Write-back target port |
| wb_addr | output | AW | Write-back word address |
| wb_data | output | DW | Write-back data |
| sbe_flag | output | 1 | Sticky threshold-reached flag |

## Verification
The bench builds the block with two entries, an 8-bit address and a 4-bit counter. Two entries mean that a third distinct single-bit fault already forces round-robin replacement and pointer wrap. The narrow counter lets sixteen events reach saturation at 15, so a threshold of 15 and the disabled threshold of 0 can both be checked. The small address space makes random traffic hit cached entries, and the same address on both ports, often enough.

// File: rtl/hard_err_cache.sv
module hard_err_cache #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int N  = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          flag_clr,
  input  logic [CW-1:0] thresh,
  input  logic          rd_valid,
  input  logic          rd_port,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_sbe,
  input  logic          rd_dbe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          retry,
  output logic          wb_valid,
  output logic          wb_port,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          sbe_flag
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  ev;
  logic [N-1:0]  ep;
  logic [AW-1:0] ea [N];
  logic [DW-1:0] ed [N];
  logic [PW-1:0] ptr, fidx, victim;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          hit;
  logic [DW-1:0] hdat;

  always_comb begin
    hit  = 1'b0;
    hdat = '0;
    for (int i = 0; i < N; i++)
      if (ev[i] && ep[i] == rd_port && ea[i] == rd_addr) begin
        hit  = 1'b1;
        hdat = ed[i];
      end
  end

  always_comb begin
    fidx = '0;
    for (int i = N-1; i >= 0; i--)
      if (!ev[i]) fidx = PW'(i);
  end

  wire any_free = ~&ev;
  wire sbe_ev   = rd_valid && !hit && !rd_dbe && rd_sbe;
  wire dbe_ev   = rd_valid && !hit && rd_dbe;
  assign victim  = any_free ? fidx : ptr;
  assign cnt_nxt = (&cnt) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      retry     <= 1'b0;
      wb_valid  <= 1'b0;
      wb_port   <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= rd_valid && !sbe_ev;
      rsp_data  <= (rd_valid && !sbe_ev) ? (hit ? hdat : rd_data) : '0;
      rsp_err   <= dbe_ev;
      wb_valid  <= sbe_ev;
      wb_port   <= sbe_ev ? rd_port : 1'b0;
      wb_addr   <= sbe_ev ? rd_addr : '0;
      wb_data   <= sbe_ev ? rd_data : '0;
      retry     <= wb_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev  <= '0;
      ep  <= '0;
      ptr <= '0;
      cnt <= '0;
      for (int i = 0; i < N; i++) begin
        ea[i] <= '0;
        ed[i] <= '0;
      end
    end else if (clr) begin
      ev  <= '0;
      ptr <= '0;
      cnt <= '0;
    end else if (sbe_ev) begin
      ev[victim] <= 1'b1;
      ep[victim] <= rd_port;
      ea[victim] <= rd_addr;
      ed[victim] <= rd_data;
      cnt        <= cnt_nxt;
      if (!any_free) ptr <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sbe_flag <= 1'b0;
    else if (sbe_ev && !clr && thresh != '0 && cnt_nxt >= thresh)
      sbe_flag <= 1'b1;
    else if (flag_clr)
      sbe_flag <= 1'b0;
  end
endmodule

module hard_err_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_clr,
  input logic rsp_valid,
  input logic rsp_err,
  input logic retry,
  input logic wb_valid,
  input logic sbe_flag
);
  // R3
  retry_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> retry);
  // R3
  retry_only_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> !retry);
  // R2
  wb_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, wb_valid}));
  // R6
  err_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_flag && !flag_clr) |=> sbe_flag);
  // R9
  flag_rise_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sbe_flag) |-> wb_valid);
endmodule

bind hard_err_cache hard_err_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .retry(retry), .wb_valid(wb_valid), .sbe_flag(sbe_flag)
);

// File: tb/hard_err_cache_bench.sv
`timescale 1ns/1ps
module hard_err_cache_bench;
  localparam int AW = 8, DW = 32, N = 2, CW = 4;

  logic clk = 0, rst_n = 0, clr = 0, flag_clr = 0;
  logic [CW-1:0] thresh = 0;
  logic rd_valid = 0, rd_port = 0, rd_sbe = 0, rd_dbe = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [DW-1:0] rd_data = 0;
  logic rsp_valid, rsp_err, retry, wb_valid, wb_port, sbe_flag;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #2 clk = ~clk;

  hard_err_cache #(.AW(AW), .DW(DW), .N(N), .CW(CW)) u_hard_err_cache (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flag_clr(flag_clr), .thresh(thresh),
    .rd_valid(rd_valid), .rd_port(rd_port), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .retry(retry), .wb_valid(wb_valid), .wb_port(wb_port),
    .wb_addr(wb_addr), .wb_data(wb_data), .sbe_flag(sbe_flag));

  int errors = 0, checks = 0;
  string scen = "R12 reset";

  // reference model state
  bit mv[N]; bit mp[N]; int ma[N]; logic [DW-1:0] md[N];
  int mptr, mcnt; bit mflag;
  bit e_rv, e_re, e_rt, e_wv, e_wp; logic [DW-1:0] e_rd, e_wd; int e_wa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      mptr = 0; mcnt = 0; mflag = 0;
      e_rv = 0; e_re = 0; e_rt = 0; e_wv = 0; e_wp = 0; e_rd = 0; e_wd = 0; e_wa = 0;
    end else begin
      int hidx, slot;
      bit sbe, dbe;
      hidx = -1;
      for (int i = 0; i < N; i++)
        if (mv[i] && mp[i] == rd_port && ma[i] == int'(rd_addr)) hidx = i;
      sbe = rd_valid && hidx < 0 && !rd_dbe && rd_sbe;
      dbe = rd_valid && hidx < 0 && rd_dbe;
      e_rt = e_wv;
      e_rv = rd_valid && !sbe;
      e_re = dbe;
      e_rd = !e_rv ? '0 : (hidx >= 0 ? md[hidx] : rd_data);
      e_wv = sbe;
      e_wp = sbe ? rd_port : 0;
      e_wa = sbe ? int'(rd_addr) : 0;
      e_wd = sbe ? rd_data : '0;
      if (sbe && !clr && thresh != 0 && ((mcnt == 15) ? 15 : mcnt + 1) >= int'(thresh)) mflag = 1;
      else if (flag_clr) mflag = 0;
      if (clr) begin
        foreach (mv[i]) mv[i] = 0;
        mptr = 0; mcnt = 0;
      end else if (sbe) begin
        slot = -1;
        for (int i = N-1; i >= 0; i--) if (!mv[i]) slot = i;
        if (slot < 0) begin slot = mptr; mptr = (mptr + 1) % N; end
        mv[slot] = 1; mp[slot] = rd_port; ma[slot] = int'(rd_addr); md[slot] = rd_data;
        if (mcnt < 15) mcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", scen, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(rsp_valid == e_rv, "rsp_valid R4/R7", rsp_valid, e_rv);
    chk(rsp_data == e_rd, "rsp_data R1/R4", rsp_data, e_rd);
    chk(rsp_err == e_re, "rsp_err R6", rsp_err, e_re);
    chk(retry == e_rt, "retry R3", retry, e_rt);
    chk(wb_valid == e_wv, "wb_valid R2", wb_valid, e_wv);
    chk(wb_port == e_wp && int'(wb_addr) == e_wa && wb_data == e_wd, "wb fields R2",
        {wb_port, wb_addr, wb_data}, {e_wp, AW'(e_wa), e_wd});
    chk(sbe_flag == mflag, "sbe_flag R9/R10", sbe_flag, mflag);
  end

  task automatic rd(input bit p, input int a, input logic [DW-1:0] d, input bit s, input bit b);
    rd_valid = 1; rd_port = p; rd_addr = AW'(a); rd_data = d; rd_sbe = s; rd_dbe = b;
    @(negedge clk);
    rd_valid = 0; rd_sbe = 0; rd_dbe = 0; rd_data = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulse_clr(input bit c, input bit f);
    clr = c; flag_clr = f;
    @(negedge clk);
    clr = 0; flag_clr = 0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; thresh = 3;
    @(negedge clk);
    scen = "R7 clean miss";      rd(0, 5, 32'hA5A5_0001, 0, 0);
    scen = "R6 double error";    rd(0, 6, 32'hDEAD_0002, 1, 1);
    scen = "R6 not cached";      rd(0, 6, 32'h1111_0003, 0, 0);
    scen = "R1 R2 R3 capture";   rd(0, 9, 32'hC0DE_0009, 1, 0);
    scen = "R4 hit";             rd(0, 9, 32'hBAD0_BAD0, 1, 1);
    scen = "R5 port match";      rd(1, 9, 32'h5555_0009, 0, 0);
    scen = "R8 fill slot1";      rd(1, 9, 32'hC0DE_1009, 1, 0);
    scen = "R8 replace slot0";   rd(0, 20, 32'hC0DE_0020, 1, 0);
    scen = "R8 evicted";         rd(0, 9, 32'h7777_0009, 0, 0);
    scen = "R8 kept";            rd(1, 9, 32'h0, 0, 1);
    scen = "R8 wrap slot1";      rd(0, 30, 32'hC0DE_0030, 1, 0);
    scen = "R8 slot1 evicted";   rd(1, 9, 32'h8888_0009, 0, 0);
    scen = "R10 flag held";      repeat (4) @(negedge clk);
    scen = "R10 flag clear";     pulse_clr(0, 1);
    scen = "R11 clear";          pulse_clr(1, 0);
    scen = "R11 invalid";        rd(0, 30, 32'h9999_0030, 0, 0);
    scen = "R9 saturate";        thresh = 15;
    for (int k = 0; k < 17; k++) rd(k[0], 40 + k, 32'h5A00_0000 + k, 1, 0);
    scen = "R10 set wins";
    rd_valid = 1; rd_port = 1; rd_addr = 100; rd_data = 32'h1234; rd_sbe = 1; flag_clr = 1;
    @(negedge clk);
    rd_valid = 0; rd_sbe = 0; flag_clr = 0; @(negedge clk);
    scen = "R9 zero threshold";  pulse_clr(1, 1); thresh = 0;
    for (int k = 0; k < 17; k++) rd(0, 60 + k, 32'h6B00_0000 + k, 1, 0);
    scen = "R11 clr vs capture";
    rd_valid = 1; rd_port = 0; rd_addr = 3; rd_data = 32'h33; rd_sbe = 1; clr = 1;
    @(negedge clk);
    rd_valid = 0; rd_sbe = 0; clr = 0; @(negedge clk);
    rd(0, 3, 32'h44, 0, 0);
    scen = "random R1 R4 R5 R8"; thresh = 5;
    for (int k = 0; k < 2000; k++) begin
      rd_valid = ($urandom % 3) != 0;
      rd_port  = $urandom % 2;
      rd_addr  = AW'($urandom % 4);
      rd_data  = $urandom;
      rd_sbe   = ($urandom % 3) == 0;
      rd_dbe   = ($urandom % 8) == 0;
      clr      = ($urandom % 50) == 0;
      flag_clr = ($urandom % 40) == 0;
      @(negedge clk);
    end
    rd_valid = 0; rd_sbe = 0; rd_dbe = 0; clr = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule